// File: doc/BRIEF.md
# Scan-Line Scatter-Gather Program Generator

This block turns the description of one video field into a stream of two-word DMA instructions. Its inputs are the byte offset of the first line, the bytes per line, the padding bytes between lines, the line count, the field parity and a flag that asks for a leading jump. Memory is a list of chunks, each with a base address and a length. The block reads this list one entry at a time through an indexed table port: it drives the index, and the table returns that entry's base and length in the same cycle.

For every scan line the block walks forward to the chunk that holds the current offset. If the line fits in what is left of that chunk, it emits a single line-start pair. If not, it emits a split line-start fragment and then continuation fragments, one for each further chunk the line touches. Each continuation carries how many bytes of the line come before it. Pairs leave on a valid/ready stream. `done_o` rises after the last line is accepted, and `err_o` rises if the chunk list runs out first.

Top module: `sg_prog_gen`

## Requirements
- R1: When `jump_i` is set at start, the first pair is a jump: word0 = 0xB000_0000 (op code 3), word1 = 0.
- R2: Next comes one sync pair with word1 = 0: op 1 (word0 0x9000_0000) when `odd_i` was 1, otherwise op 2 (word0 0xA000_0000).
- R3: Before each line, while the offset is nonzero and at least the current chunk length, that length is subtracted from the offset and the chunk index advances by one.
- R4: A line that fits in the rest of the current chunk gives one pair with op 4, type 0, count = bytes per line and word1 = chunk base + offset. The offset then grows by bytes per line.
- R5: A line that does not fit starts with a pair with op 4, type 7, count = length minus offset, and word1 = chunk base + offset.
- R6: Each later fragment of a split line has op 5, start field = number of line bytes already emitted for that line, and word1 = chunk base. It takes the whole chunk while the bytes still needed exceed the chunk length; otherwise it takes the leftover, and the leftover becomes the next offset.
- R7: After every line the padding count is added to the offset.
- R8: While `instr_valid_o` is high and `instr_ready_i` is low, the valid and the pair hold unchanged. Each pair is accepted exactly once.
- R9: `done_o` rises in the cycle after the last line's final pair is accepted, with `instr_valid_o` low from then on. A line count of zero finishes right after the sync pair. Reset leaves `done_o`, `err_o` and `instr_valid_o` low with index 0.
- R10: If a chunk beyond entry `chunk_cnt_i`-1 is needed, `err_o` rises, no further pair is offered and `done_o` stays low.
- R11: Word0 is laid out as bit 31 = 1, op in [30:28], bit 27 = 0, type in [26:24], start in [23:12] and count in [11:0]. `instr_o[31:0]` is word0 and `instr_o[63:32]` is word1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken when idle, done or in error |
| offset_i | input | OFF_W | Start byte offset into the chunk list |
| line_bytes_i | input | 12 | Bytes per scan line (nonzero) |
| pad_i | input | 12 | Padding bytes after each line |
| lines_i | input | LINES_W | Number of lines |
| odd_i | input | 1 | Field parity, 1 selects sync-odd |
| jump_i | input | 1 | Emit a leading jump pair |
| chunk_cnt_i | input | IDX_W+1 | Number of valid chunk entries |
| chunk_idx_o | output | IDX_W | Chunk table index |
| chunk_base_i | input | ADDR_W | Base address of the indexed chunk |
| chunk_len_i | input | LEN_W | Length of the indexed chunk (nonzero) |
| instr_valid_o | output | 1 | Pair valid |
| instr_ready_i | input | 1 | Consumer ready |
| instr_o | output | 32+ADDR_W | Instruction pair {word1, word0} |
| done_o | output | 1 | Program complete |
| err_o | output | 1 | Chunk list exhausted |

## Verification
Two events can land on the same edge. One is the acceptance of a line's final fragment. The other is the move to the next chunk that follows from the offset rolling past a border, which happens when the leftover plus padding reaches the chunk length (R3, R6, R7). The benches set up a split line whose leftover plus padding lands just past the next chunk, and another run where the chunk list ends during a split. Consumer stalls are inserted at chosen pairs. The emitted addresses and start fields are compared with values computed by hand, and the run must end with `done_o` or `err_o` as expected.

// File: rtl/sg_gen_pkg.sv
package sg_gen_pkg;
  localparam int unsigned FLD_W = 12;

  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_SYNC_ODD  = 3'd1,
    OP_SYNC_EVEN = 3'd2,
    OP_JUMP      = 3'd3,
    OP_LINE      = 3'd4,
    OP_CONT      = 3'd5
  } op_e;

  localparam logic [2:0] TYPE_PLAIN = 3'd0;
  localparam logic [2:0] TYPE_SPLIT = 3'd7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_JUMP, ST_SYNC, ST_SEEK, ST_LINE, ST_FRAG, ST_DONE, ST_ERR
  } state_e;
endpackage

// File: rtl/sg_instr_enc.sv
module sg_instr_enc
  import sg_gen_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  op_e               op_i,
  input  logic [2:0]        type_i,
  input  logic [FLD_W-1:0]  start_i,
  input  logic [FLD_W-1:0]  count_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W+31:0] pair_o
);
  logic [31:0] word0;
  assign word0  = {1'b1, op_i, 1'b0, type_i, start_i, count_i};
  assign pair_o = {addr_i, word0};
endmodule

// File: rtl/sg_frag_calc.sv
module sg_frag_calc #(
  parameter int unsigned OFF_W = 24,
  parameter int unsigned LEN_W = 16,
  parameter int unsigned CNT_W = 12
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [CNT_W-1:0] bpl_i,
  input  logic [CNT_W-1:0] placed_i,
  output logic             skip_o,
  output logic             fits_o,
  output logic [LEN_W-1:0] remain_o,
  output logic [CNT_W-1:0] todo_o,
  output logic             last_frag_o
);
  localparam int unsigned WW = (OFF_W > LEN_W) ? OFF_W : LEN_W;
  localparam int unsigned CW = (WW > CNT_W) ? WW : CNT_W;

  logic [WW-1:0] off_w, len_w;
  assign off_w = WW'(off_i);
  assign len_w = WW'(len_i);

  assign skip_o   = (off_w != '0) && (off_w >= len_w);
  // only meaningful once skip_o is low, so offset < length
  assign remain_o = len_i - off_i[LEN_W-1:0];
  assign fits_o   = CW'(bpl_i) <= CW'(remain_o);

  assign todo_o      = bpl_i - placed_i;
  assign last_frag_o = CW'(todo_o) <= CW'(len_i);
endmodule

// File: rtl/sg_prog_gen.sv
module sg_prog_gen
  import sg_gen_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned OFF_W   = 24,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned LINES_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [OFF_W-1:0]   offset_i,
  input  logic [FLD_W-1:0]   line_bytes_i,
  input  logic [FLD_W-1:0]   pad_i,
  input  logic [LINES_W-1:0] lines_i,
  input  logic               odd_i,
  input  logic               jump_i,
  input  logic [IDX_W:0]     chunk_cnt_i,
  output logic [IDX_W-1:0]   chunk_idx_o,
  input  logic [ADDR_W-1:0]  chunk_base_i,
  input  logic [LEN_W-1:0]   chunk_len_i,
  output logic               instr_valid_o,
  input  logic               instr_ready_i,
  output logic [ADDR_W+31:0] instr_o,
  output logic               done_o,
  output logic               err_o
);
  state_e             state_q;
  logic [IDX_W-1:0]   idx_q;
  logic [OFF_W-1:0]   off_q;
  logic [FLD_W-1:0]   placed_q, bpl_q, pad_q;
  logic [LINES_W-1:0] line_q, lines_q;
  logic               odd_q;

  logic             skip, fits, last_frag;
  logic [LEN_W-1:0] remain;
  logic [FLD_W-1:0] todo;

  sg_frag_calc #(.OFF_W(OFF_W), .LEN_W(LEN_W), .CNT_W(FLD_W)) u_calc (
    .off_i      (off_q),
    .len_i      (chunk_len_i),
    .bpl_i      (bpl_q),
    .placed_i   (placed_q),
    .skip_o     (skip),
    .fits_o     (fits),
    .remain_o   (remain),
    .todo_o     (todo),
    .last_frag_o(last_frag)
  );

  logic fire, has_next, idx_ok, last_line;
  assign fire      = instr_valid_o & instr_ready_i;
  assign has_next  = ({1'b0, idx_q} + (IDX_W+1)'(1)) < chunk_cnt_i;
  assign idx_ok    = {1'b0, idx_q} < chunk_cnt_i;
  assign last_line = (line_q + LINES_W'(1)) == lines_q;

  // emit side: purely a function of registered state and the table read
  op_e               op;
  logic [2:0]        typ;
  logic [FLD_W-1:0]  fld_start, fld_cnt;
  logic [ADDR_W-1:0] addr;

  always_comb begin
    instr_valid_o = 1'b0;
    op        = OP_NONE;
    typ       = TYPE_PLAIN;
    fld_start = '0;
    fld_cnt   = '0;
    addr      = '0;
    unique case (state_q)
      ST_JUMP: begin
        instr_valid_o = 1'b1;
        op = OP_JUMP;
      end
      ST_SYNC: begin
        instr_valid_o = 1'b1;
        op = odd_q ? OP_SYNC_ODD : OP_SYNC_EVEN;
      end
      ST_LINE: begin
        instr_valid_o = 1'b1;
        op   = OP_LINE;
        addr = chunk_base_i + ADDR_W'(off_q);
        if (fits) begin
          fld_cnt = bpl_q;
        end else begin
          typ     = TYPE_SPLIT;
          fld_cnt = FLD_W'(remain);
        end
      end
      ST_FRAG: begin
        instr_valid_o = 1'b1;
        op        = OP_CONT;
        fld_start = placed_q;
        addr      = chunk_base_i;
        fld_cnt   = last_frag ? todo : FLD_W'(chunk_len_i);
      end
      default: ;
    endcase
  end

  sg_instr_enc #(.ADDR_W(ADDR_W)) u_enc (
    .op_i   (op),
    .type_i (typ),
    .start_i(fld_start),
    .count_i(fld_cnt),
    .addr_i (addr),
    .pair_o (instr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      off_q    <= '0;
      placed_q <= '0;
      bpl_q    <= '0;
      pad_q    <= '0;
      line_q   <= '0;
      lines_q  <= '0;
      odd_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE, ST_ERR: begin
          if (start_i) begin
            idx_q    <= '0;
            off_q    <= offset_i;
            placed_q <= '0;
            bpl_q    <= line_bytes_i;
            pad_q    <= pad_i;
            line_q   <= '0;
            lines_q  <= lines_i;
            odd_q    <= odd_i;
            state_q  <= jump_i ? ST_JUMP : ST_SYNC;
          end
        end
        ST_JUMP: if (fire) state_q <= ST_SYNC;
        ST_SYNC: if (fire) state_q <= (lines_q == '0) ? ST_DONE : ST_SEEK;
        ST_SEEK: begin
          if (!idx_ok) begin
            state_q <= ST_ERR;
          end else if (skip) begin
            if (has_next) begin
              idx_q <= idx_q + IDX_W'(1);
              off_q <= off_q - OFF_W'(chunk_len_i);
            end else begin
              state_q <= ST_ERR;
            end
          end else begin
            state_q <= ST_LINE;
          end
        end
        ST_LINE: begin
          if (fire) begin
            if (fits) begin
              off_q   <= off_q + OFF_W'(bpl_q) + OFF_W'(pad_q);
              line_q  <= line_q + LINES_W'(1);
              state_q <= last_line ? ST_DONE : ST_SEEK;
            end else begin
              placed_q <= FLD_W'(remain);
              if (has_next) begin
                idx_q   <= idx_q + IDX_W'(1);
                state_q <= ST_FRAG;
              end else begin
                state_q <= ST_ERR;
              end
            end
          end
        end
        ST_FRAG: begin
          if (fire) begin
            if (last_frag) begin
              off_q    <= OFF_W'(todo) + OFF_W'(pad_q);
              placed_q <= '0;
              line_q   <= line_q + LINES_W'(1);
              state_q  <= last_line ? ST_DONE : ST_SEEK;
            end else begin
              placed_q <= placed_q + FLD_W'(chunk_len_i);
              if (has_next) idx_q <= idx_q + IDX_W'(1);
              else          state_q <= ST_ERR;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign chunk_idx_o = idx_q;
  assign done_o      = (state_q == ST_DONE);
  assign err_o       = (state_q == ST_ERR);
endmodule

// File: rtl/sg_prog_gen_chk.sv
module sg_prog_gen_chk
  import sg_gen_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               instr_valid_o,
  input logic               instr_ready_i,
  input logic [ADDR_W+31:0] instr_o,
  input logic               done_o,
  input logic               err_o,
  input logic [IDX_W-1:0]   chunk_idx_o,
  input logic [IDX_W:0]     chunk_cnt_i
);
  logic [2:0] op_f, type_f;
  assign op_f   = instr_o[30:28];
  assign type_f = instr_o[26:24];

  assert_stall_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_o && !instr_ready_i |=> instr_valid_o && $stable(instr_o));

  assert_done_err_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  assert_quiet_after_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> !instr_valid_o);

  assert_idx_in_list_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_o && (op_f == OP_LINE || op_f == OP_CONT) |-> {1'b0, chunk_idx_o} < chunk_cnt_i);

  assert_split_then_cont_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_o && instr_ready_i && op_f == OP_LINE && type_f == TYPE_SPLIT
    |=> !instr_valid_o || op_f == OP_CONT);

  assert_count_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_o && (op_f == OP_LINE || op_f == OP_CONT) |-> instr_o[11:0] != '0);

  assert_word_marker_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_o |-> instr_o[31] && !instr_o[27]);
endmodule

bind sg_prog_gen sg_prog_gen_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sg_prog_gen_test.sv
module sg_prog_gen_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start = 1'b0;
  logic [23:0] offset = '0;
  logic [11:0] bpl = '0, pad = '0;
  logic [9:0]  lines = '0;
  logic        odd = 1'b0, jump = 1'b0;
  logic [4:0]  cnt = '0;
  logic [3:0]  idx;
  logic        valid, ready = 1'b0, done, err;
  logic [63:0] instr;
  logic [31:0] base_t [16];
  logic [15:0] len_t  [16];

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  sg_prog_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .offset_i(offset),
    .line_bytes_i(bpl), .pad_i(pad), .lines_i(lines), .odd_i(odd), .jump_i(jump),
    .chunk_cnt_i(cnt), .chunk_idx_o(idx), .chunk_base_i(base_t[idx]),
    .chunk_len_i(len_t[idx]), .instr_valid_o(valid), .instr_ready_i(ready),
    .instr_o(instr), .done_o(done), .err_o(err)
  );

  // {stall, word1, word0}; stall adds two held cycles before acceptance
  localparam logic [64:0] VEC_A [7] = '{
    {1'b1, 32'h0000_0000, 32'hB000_0000},  // R1 jump
    {1'b0, 32'h0000_0000, 32'h9000_0000},  // R2 sync odd
    {1'b1, 32'h0000_1014, 32'hC000_003C},  // R4 fits
    {1'b0, 32'h0000_105A, 32'hC700_000A},  // R5 R7 split head after padding
    {1'b1, 32'h0000_2000, 32'hD000_A032},  // R6 final fragment
    {1'b0, 32'h0000_300A, 32'hC000_003C},  // R3 skip to chunk 2
    {1'b1, 32'h0000_3050, 32'hC000_003C}   // R4 R7 next line
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic get_pair(input logic [63:0] exp, input int stall, input string tag);
    int w = 0;
    while (!valid && w < 64) begin @(negedge clk); w++; end
    for (int i = 0; i < stall; i++) begin
      chk(valid && instr == exp, {tag, " R8 hold"}, instr, exp);
      @(negedge clk);
    end
    chk(valid && instr == exp, tag, instr, exp);
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
  endtask

  task automatic kick(input logic [23:0] o, input logic [11:0] b, input logic [11:0] p,
                      input logic [9:0] n, input bit od, input bit j);
    @(negedge clk);
    offset = o; bpl = b; pad = p; lines = n; odd = od; jump = j;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic load_a();
    base_t[0] = 32'h1000; len_t[0] = 16'd100;
    base_t[1] = 32'h2000; len_t[1] = 16'd50;
    base_t[2] = 32'h3000; len_t[2] = 16'd300;
    base_t[3] = 32'h4000; len_t[3] = 16'd1000;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R9 actual=%h expected=%h", 64'(done), 64'(1));
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin base_t[i] = '0; len_t[i] = 16'd1; end
    repeat (3) @(negedge clk);
    chk(!valid && !done && !err && idx == '0, "R9 reset state",
        {valid, done, err, 57'd0, idx}, 64'd0);
    rst_ni = 1'b1;

    // scenario A: table walk with stalls
    load_a(); cnt = 5'd4;
    kick(24'd20, 12'd60, 12'd10, 10'd4, 1'b1, 1'b1);
    for (int i = 0; i < 7; i++)
      get_pair(VEC_A[i][63:0], VEC_A[i][64] ? 2 : 0, $sformatf("vecA[%0d] R11", i));
    chk(done && !err && !valid, "R9 done after last line A", {62'd0, done, err}, 64'd2);
    repeat (3) @(negedge clk);
    chk(done && !valid, "R9 done holds, no pair", {62'd0, done, valid}, 64'd2);

    // scenario B: middle chunks, even parity, no jump
    base_t[0] = 32'h8000; len_t[0] = 16'd16;
    base_t[1] = 32'h9000; len_t[1] = 16'd8;
    base_t[2] = 32'hA000; len_t[2] = 16'd4;
    base_t[3] = 32'hB000; len_t[3] = 16'd100;
    kick(24'd4, 12'd30, 12'd2, 10'd2, 1'b0, 1'b0);
    get_pair({32'h0, 32'hA000_0000}, 0, "R2 sync even, R1 no jump");
    get_pair({32'h8004, 32'hC700_000C}, 1, "R5 split head B");
    get_pair({32'h9000, 32'hD000_C008}, 0, "R6 middle chunk start 12");
    get_pair({32'hA000, 32'hD001_4004}, 2, "R6 middle chunk start 20");
    get_pair({32'hB000, 32'hD001_8006}, 0, "R6 leftover start 24");
    get_pair({32'hB008, 32'hC000_001E}, 0, "R7 R6 offset = leftover + pad");
    chk(done && !err, "R9 done B", {62'd0, done, err}, 64'd2);

    // scenario C: multi-chunk seek then list exhausted mid split
    load_a(); cnt = 5'd2;
    kick(24'd130, 12'd60, 12'd0, 10'd1, 1'b1, 1'b0);
    get_pair({32'h0, 32'h9000_0000}, 0, "R2 sync odd C");
    get_pair({32'h201E, 32'hC700_0014}, 0, "R3 two-chunk seek, R5 split");
    chk(err && !done && !valid, "R10 error raised",
        {61'd0, err, done, valid}, 64'd4);
    repeat (4) @(negedge clk);
    chk(err && !done && !valid, "R10 stays stopped",
        {61'd0, err, done, valid}, 64'd4);

    // scenario D: zero lines
    cnt = 5'd4;
    kick(24'd0, 12'd8, 12'd0, 10'd0, 1'b0, 1'b1);
    chk(!err, "R10 error cleared by start", {63'd0, err}, 64'd0);
    get_pair({32'h0, 32'hB000_0000}, 1, "R1 jump D");
    get_pair({32'h0, 32'hA000_0000}, 0, "R2 sync even D");
    chk(done && !valid, "R9 zero lines done", {62'd0, done, valid}, 64'd2);

    finish_run();
  end
endmodule